// File: doc/BRIEF.md
# I2C Master Clock Phase Timer

This block produces the serial clock waveform for an I2C master while it is enabled. It has two stages. A programmable prescaler divides the system clock into a stream of single-cycle function-clock ticks. A phase counter then counts those ticks to time the high phase and the low phase of the serial clock, each from its own field. Software supplies a divisor in minus-one form and a packed timing word that holds one field for the high phase and one for the low phase. Both fields use the same encoding.

The clock output is open-drain style: the block either pulls the line low or releases it. A single-cycle strobe marks the first cycle of each new level, so an external bit engine can shift or sample data there. Start and stop sequencing, data handling and arbitration belong to the surrounding controller. Changes to the divisor or the timing word wait for the next phase boundary, so the current phase always finishes with the values it started with.

Top module: `scl_timing_gen`

## Requirements
- R1: After reset, and before the first enable, `scl_drive_low` is 0 and both strobes are 0.
- R2: The divisor input holds the divisor minus one. A value of V gives one function-clock tick every V+1 system clocks. V=0 gives a tick on every system clock.
- R3: The high-phase field is `timing_word[6:4]` and the low-phase field is `timing_word[2:0]`. A phase whose field is F lasts exactly (V+1)*(F+2) system clocks.
- R4: The two fields are decoded identically. For example, word 0x33 with V=17 gives 90 cycles low and 90 cycles high.
- R5: The clock period equals the high length plus the low length. No extra cycle is added to either phase, including at the extreme fields 0 (2 ticks) and 7 (9 ticks).
- R6: On the first clock edge at which `enable` is sampled high while the block is idle, the line is pulled low in the next cycle and `scl_fall_stb` is high in that cycle. The first phase is always a low phase.
- R7: On a clock edge at which `enable` is sampled low, the line is released in the next cycle, no strobe is raised, and the timers reset. Re-enabling starts a fresh full low phase.
- R8: The divisor and the timing word are sampled only at a phase boundary (entry or level change). Changes made mid-phase do not alter the length of the current phase.
- R9: `scl_fall_stb` is high only in the first cycle of a low level and `scl_rise_stb` only in the first cycle of a released level. The two are never high together and never in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Run the clock timer; low releases the line and clears the timers |
| div_m1 | input | DIV_W (8) | Prescaler divisor minus one |
| timing_word | input | TW_W (8) | Packed phase fields: high in [6:4], low in [2:0] |
| scl_drive_low | output | 1 | 1 pulls the serial clock line low, 0 releases it |
| scl_rise_stb | output | 1 | One-cycle strobe in the first cycle of a released level |
| scl_fall_stb | output | 1 | One-cycle strobe in the first cycle of a low level |

## Verification
A wrong tick count or a wrong divisor latch inside the block shows up at the ports as a strobe and a level change that come early or late. This is visible no later than the end of the phase that is affected, so a per-cycle reference model catches it within one phase length. A stale or wrongly selected field shows in the very next phase, for example a low phase timed with the high field. A lost `running` state shows one cycle after an enable edge, as a missing fall strobe or a line left released.

// File: rtl/scl_tg_pkg.sv
// Shared definitions for the I2C master clock phase timer.
// Assumes the phase fields are biased by a fixed constant of two ticks.
package scl_tg_pkg;
    // Level currently driven on the serial clock line
    typedef enum logic {
        PH_HIGH = 1'b0,
        PH_LOW  = 1'b1
    } scl_phase_e;

    // Minimum phase length in function-clock ticks (field value 0)
    localparam int FIELD_BIAS = 2;
endpackage

// File: rtl/scl_prescaler.sv
// Function-clock prescaler: emits a one-cycle tick every (div_act+1)
// system clocks while run is high. Assumes div_act is stable between
// ticks; its owner changes it only at a phase boundary, where this
// counter also wraps to zero.
module scl_prescaler #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div_act,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;

    // Tick fires when the count reaches the terminal value
    assign tick = run && (cnt == div_act);

    // Count system clocks, wrap on every tick, hold at zero when idle
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/scl_phase_load.sv
// Phase length decoder: selects the high or the low field from the
// packed timing word and adds the fixed bias, giving the tick count
// of the next phase. Both fields use the same decode.
module scl_phase_load
    import scl_tg_pkg::*;
#(
    parameter int TW_W    = 8,
    parameter int FIELD_W = 3,
    parameter int HI_LSB  = 4,
    parameter int LO_LSB  = 0,
    parameter int PH_W    = 4
) (
    input  logic [TW_W-1:0] timing_word,
    input  logic            next_is_low,
    output logic [PH_W-1:0] load_ticks
);
    logic [FIELD_W-1:0] hi_field;
    logic [FIELD_W-1:0] lo_field;
    logic [FIELD_W-1:0] sel_field;
    logic               unused_tw;

    assign hi_field  = timing_word[HI_LSB +: FIELD_W];
    assign lo_field  = timing_word[LO_LSB +: FIELD_W];
    assign unused_tw = ^timing_word;

    // Pick the field that belongs to the phase about to begin
    always_comb begin
        sel_field  = next_is_low ? lo_field : hi_field;
        load_ticks = PH_W'(sel_field) + PH_W'(FIELD_BIAS);
    end
endmodule

// File: rtl/scl_phase_ctr.sv
// Phase sequencer: tracks the clock level, counts function-clock ticks
// down to the end of each phase, toggles the level and raises the edge
// strobes. It latches the divisor at every phase boundary. Assumes the
// tick input comes from a prescaler that restarts whenever running is low.
module scl_phase_ctr
    import scl_tg_pkg::*;
#(
    parameter int DIV_W = 8,
    parameter int PH_W  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             tick,
    input  logic [DIV_W-1:0] div_m1,
    input  logic [PH_W-1:0]  load_ticks,
    output logic             running,
    output logic             next_is_low,
    output logic [DIV_W-1:0] div_act,
    output logic             drive_low,
    output logic             rise_stb,
    output logic             fall_stb
);
    scl_phase_e       phase;
    logic [PH_W-1:0]  ticks_left;
    logic             phase_end;

    // Next phase is low on entry or after a high phase
    assign next_is_low = !running || (phase == PH_HIGH);
    assign phase_end   = running && tick && (ticks_left == PH_W'(1));
    assign drive_low   = (phase == PH_LOW);

    // Sequence the phases and latch the settings at each boundary
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            running    <= 1'b0;
            phase      <= PH_HIGH;
            ticks_left <= '0;
            div_act    <= '0;
            rise_stb   <= 1'b0;
            fall_stb   <= 1'b0;
        end else begin
            rise_stb <= 1'b0;
            fall_stb <= 1'b0;
            if (!enable) begin
                running    <= 1'b0;
                phase      <= PH_HIGH;
                ticks_left <= '0;
            end else if (!running) begin
                running    <= 1'b1;
                phase      <= PH_LOW;
                fall_stb   <= 1'b1;
                ticks_left <= load_ticks;
                div_act    <= div_m1;
            end else if (phase_end) begin
                phase      <= (phase == PH_LOW) ? PH_HIGH : PH_LOW;
                rise_stb   <= (phase == PH_LOW);
                fall_stb   <= (phase == PH_HIGH);
                ticks_left <= load_ticks;
                div_act    <= div_m1;
            end else if (tick) begin
                ticks_left <= ticks_left - 1'b1;
            end
        end
    end
endmodule

// File: rtl/scl_timing_gen.sv
// I2C master clock phase timer top: a prescaler feeding a phase
// sequencer, with a field decoder choosing each phase length.
// Assumes the surrounding controller handles start/stop and data.
module scl_timing_gen #(
    parameter int DIV_W   = 8,
    parameter int TW_W    = 8,
    parameter int FIELD_W = 3,
    parameter int HI_LSB  = 4,
    parameter int LO_LSB  = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic [DIV_W-1:0] div_m1,
    input  logic [TW_W-1:0]  timing_word,
    output logic             scl_drive_low,
    output logic             scl_rise_stb,
    output logic             scl_fall_stb
);
    localparam int PH_W = $clog2((2 ** FIELD_W) + scl_tg_pkg::FIELD_BIAS);

    logic             tick;
    logic             running;
    logic             next_is_low;
    logic [DIV_W-1:0] div_act;
    logic [PH_W-1:0]  load_ticks;

    scl_prescaler #(.DIV_W(DIV_W)) u_presc (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (running),
        .div_act (div_act),
        .tick    (tick)
    );

    scl_phase_load #(
        .TW_W    (TW_W),
        .FIELD_W (FIELD_W),
        .HI_LSB  (HI_LSB),
        .LO_LSB  (LO_LSB),
        .PH_W    (PH_W)
    ) u_load (
        .timing_word (timing_word),
        .next_is_low (next_is_low),
        .load_ticks  (load_ticks)
    );

    scl_phase_ctr #(.DIV_W(DIV_W), .PH_W(PH_W)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .enable      (enable),
        .tick        (tick),
        .div_m1      (div_m1),
        .load_ticks  (load_ticks),
        .running     (running),
        .next_is_low (next_is_low),
        .div_act     (div_act),
        .drive_low   (scl_drive_low),
        .rise_stb    (scl_rise_stb),
        .fall_stb    (scl_fall_stb)
    );
endmodule

// File: rtl/scl_timing_chk.sv
// Port-level checker for the clock phase timer, bound to the top.
module scl_timing_chk (
    input logic clk,
    input logic rst_n,
    input logic enable,
    input logic scl_drive_low,
    input logic scl_rise_stb,
    input logic scl_fall_stb
);
    // R9: strobes never coincide
    a_r9_stb_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({scl_rise_stb, scl_fall_stb}));

    // R9: a strobe is never followed by another in the next cycle
    a_r9_no_back_to_back: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_rise_stb || scl_fall_stb) |=> !(scl_rise_stb || scl_fall_stb));

    // R9: fall strobe only while pulling low, rise strobe only while released
    a_r9_fall_level: assert property (@(posedge clk) disable iff (!rst_n)
        scl_fall_stb |-> scl_drive_low);
    a_r9_rise_level: assert property (@(posedge clk) disable iff (!rst_n)
        scl_rise_stb |-> !scl_drive_low);

    // R6: every pull-low edge carries a fall strobe
    a_r6_fall_marked: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(scl_drive_low) |-> scl_fall_stb);

    // R7: release while enabled carries a rise strobe
    a_r7_rise_marked: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(scl_drive_low) && $past(enable)) |-> scl_rise_stb);

    // R7: disabled means released with no strobe in the next cycle
    a_r7_disable_release: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!scl_drive_low && !scl_rise_stb && !scl_fall_stb));
endmodule

bind scl_timing_gen scl_timing_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .enable        (enable),
    .scl_drive_low (scl_drive_low),
    .scl_rise_stb  (scl_rise_stb),
    .scl_fall_stb  (scl_fall_stb)
);

// File: tb/tb_scl_timing_gen.sv
module tb_scl_timing_gen;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enable = 1'b0;
    logic [7:0] div_m1 = 8'd0;
    logic [7:0] timing_word = 8'h00;
    logic       scl_drive_low, scl_rise_stb, scl_fall_stb;

    int total = 0;
    int bad = 0;
    int cycles = 0;

    scl_timing_gen dut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .div_m1(div_m1),
        .timing_word(timing_word), .scl_drive_low(scl_drive_low),
        .scl_rise_stb(scl_rise_stb), .scl_fall_stb(scl_fall_stb)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    // Behavioural reference: system clocks left in the current level
    int  m_on = 0, m_low = 0, m_left = 0, m_rise = 0, m_fall = 0;
    always @(posedge clk) begin
        cycles++;
        m_rise = 0;
        m_fall = 0;
        if (!rst_n || !enable) begin
            m_on = 0; m_low = 0; m_left = 0;
        end else if (m_on == 0) begin
            m_on = 1; m_low = 1; m_fall = 1;
            m_left = (int'(div_m1) + 1) * (int'(timing_word[2:0]) + 2);
        end else begin
            m_left--;
            if (m_left == 0) begin
                m_low = 1 - m_low;
                if (m_low == 1) m_fall = 1; else m_rise = 1;
                m_left = (int'(div_m1) + 1) *
                         ((m_low == 1 ? int'(timing_word[2:0]) : int'(timing_word[6:4])) + 2);
            end
        end
    end

    // Per-cycle comparison against the model (R3, R9 on every cycle)
    always @(negedge clk) begin
        if (rst_n) begin
            total++;
            if (int'(scl_drive_low) != m_low || int'(scl_rise_stb) != m_rise ||
                int'(scl_fall_stb) != m_fall) begin
                bad++;
                $display("FAIL R3/R9 model cycle %0d: got low=%0d rise=%0d fall=%0d exp low=%0d rise=%0d fall=%0d",
                         cycles, scl_drive_low, scl_rise_stb, scl_fall_stb, m_low, m_rise, m_fall);
            end
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Count cycles the line stays at its present level, starting at a strobe
    task automatic run_len(output int n);
        n = 1;
        @(negedge clk);
        while (!scl_rise_stb && !scl_fall_stb && n < 5000) begin
            n++;
            @(negedge clk);
        end
    endtask

    // Restart with given settings and measure one low and one high phase
    task automatic measure(input int v, input int hi, input int lo, input string req);
        int nl, nh;
        enable = 1'b0;
        div_m1 = 8'(v);
        timing_word = 8'((hi << 4) | lo);
        repeat (2) @(negedge clk);
        enable = 1'b1;
        @(negedge clk);
        check(scl_fall_stb == 1'b1 && scl_drive_low == 1'b1, {req, " R6 entry"},
              int'(scl_drive_low), 1);
        run_len(nl);
        check(nl == (v + 1) * (lo + 2), {req, " low"}, nl, (v + 1) * (lo + 2));
        run_len(nh);
        check(nh == (v + 1) * (hi + 2), {req, " high"}, nh, (v + 1) * (hi + 2));
        check(nl + nh == (v + 1) * (lo + hi + 4), {req, " R5 period"}, nl + nh,
              (v + 1) * (lo + hi + 4));
    endtask

    initial begin
        int nl, nh;
        repeat (3) @(negedge clk);
        // R1: reset state
        check(!scl_drive_low && !scl_rise_stb && !scl_fall_stb, "R1 reset", int'(scl_drive_low), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(!scl_drive_low && !scl_rise_stb && !scl_fall_stb, "R1 idle", int'(scl_drive_low), 0);

        measure(17, 3, 3, "R4 0x33 div18");
        measure(4, 5, 6, "R3 fields");
        measure(0, 0, 0, "R2 div1 min");
        measure(0, 7, 7, "R10 R5 max field");
        measure(2, 7, 0, "R3 asymmetric");
        measure(1, 0, 7, "R4 swapped");

        // R8: change settings mid low phase
        enable = 1'b0;
        div_m1 = 8'd1;
        timing_word = 8'h11;
        repeat (2) @(negedge clk);
        enable = 1'b1;
        @(negedge clk);
        repeat (2) @(negedge clk);
        div_m1 = 8'd3;
        timing_word = 8'h55;
        nl = 3;
        @(negedge clk);
        while (!scl_rise_stb && nl < 5000) begin nl++; @(negedge clk); end
        check(nl == 6, "R8 current phase kept", nl, 6);
        run_len(nh);
        check(nh == 28, "R8 new high", nh, 28);
        run_len(nl);
        check(nl == 28, "R8 new low", nl, 28);

        // R7: disable mid phase, then restart with a full low phase
        repeat (3) @(negedge clk);
        enable = 1'b0;
        @(negedge clk);
        check(!scl_drive_low && !scl_rise_stb && !scl_fall_stb, "R7 release", int'(scl_drive_low), 0);
        repeat (4) @(negedge clk);
        check(!scl_drive_low && !scl_rise_stb && !scl_fall_stb, "R7 stays idle", int'(scl_drive_low), 0);
        div_m1 = 8'd2;
        timing_word = 8'h21;
        enable = 1'b1;
        @(negedge clk);
        check(scl_fall_stb == 1'b1, "R7 R6 restart strobe", int'(scl_fall_stb), 1);
        run_len(nl);
        check(nl == 9, "R7 fresh low phase", nl, 9);
        run_len(nh);
        check(nh == 12, "R9 high after rise strobe", nh, 12);

        enable = 1'b0;
        repeat (3) @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: actual=%0d expected=%0d", WATCHDOG, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule